// File: doc/BRIEF.md
# Interruptible Restartable Block-Copy Engine

This engine moves a counted run of 16-bit words from one address to another, one word per iteration, through a single-port memory request interface whose read data returns one cycle after the request. The caller presents a source pointer, a word count and a destination pointer, then pulses `start`. Each iteration reads one source word and writes it to the destination, then steps both pointers and the count. In code-source mode a base value is added to the source pointer for every read.

After each word is written, the engine samples an interrupt-pending line. If interrupts are also enabled, it stops early. The advanced pointers and the remaining count stay on its result outputs, so issuing the operation again with those values finishes the copy exactly. It also produces a restart program counter and a byte-position flag from the instruction-position input.

In long mode each pointer carries a high half. Before the first transfer the engine reads a bank register held at a fixed memory address and saves its value. It then writes a bank value built from both high halves. On completion, and before an interrupt exit, it writes the saved value back.

Top module: `blk_copy_engine`

## Requirements
- R1: After reset `busy`, `done`, `interrupted` and `mem_req` are all 0. A short-mode copy of N words writes destination word i with the value of source word i, in ascending order, for i from 0 to N-1. Because words are copied one at a time in ascending order, a destination that overlaps the source further up repeats the source pattern.
- R2: A copy whose remaining count is zero makes no data read or data write and reports `done`. Exactly one data read is made per word copied.
- R3: Each iteration lowers the count by 1 and raises both pointers by 1. At the end of the copy, `res_cnt`, `res_src_lo` and `res_dst_lo` equal count minus words copied, source plus words copied and destination plus words copied.
- R4: The interrupt line is sampled in the cycle of each data write. A stop is taken only if `irq_pending` and `irq_enable` are both 1 in that cycle. A pending interrupt with `irq_enable` = 0 has no effect on the copy.
- R5: When an interrupt is taken, no further data read follows and `interrupted` pulses. The result outputs hold the advanced pointers and the remaining count. Issuing the operation again with those values completes the same copy.
- R6: With `code_src` = 1, every source read goes to address source pointer + `code_base` (modulo 2^16). The result source pointer itself excludes the base.
- R7: In long mode the engine first reads address BANK_ADDR and saves the data. Before any data access it then writes BANK_ADDR with (`op_src_hi` << 2) | (`op_dst_hi` & 3), truncated to 16 bits.
- R8: In long mode the saved bank value is written back to BANK_ADDR as the last memory access, both before `done` and before `interrupted`.
- R9: On an interrupt exit with `even_pos` = 1, `restart_pc` = `pc_in` - 1 and `byte_sel` = 0. With `even_pos` = 0, `restart_pc` = `pc_in` and `byte_sel` = 1.
- R10: `busy` is 1 from the cycle after `start` until the cycle in which `done` or `interrupted` pulses, and 0 in the following cycle. `done` and `interrupted` last one cycle each and are never high together. A `start` that arrives while `busy` is ignored.
- R11: A long-mode copy with a zero count still performs the bank read, the bank write and the bank restore, and makes no data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| long_mode | input | 1 | Use two-word pointers and the bank register |
| code_src | input | 1 | Add `code_base` to every source read address |
| even_pos | input | 1 | Instruction started at an even position |
| op_src_lo | input | 16 | Source pointer, low half |
| op_src_hi | input | 16 | Source pointer, high half (long mode) |
| op_cnt | input | 16 | Words to copy |
| op_dst_lo | input | 16 | Destination pointer, low half |
| op_dst_hi | input | 16 | Destination pointer, high half (long mode) |
| code_base | input | 16 | Base added to source reads in code-source mode |
| pc_in | input | 16 | Program counter of the issuing instruction |
| irq_pending | input | 1 | Interrupt waiting |
| irq_enable | input | 1 | Interrupts allowed |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: copy finished |
| interrupted | output | 1 | One-cycle pulse: stopped for an interrupt |
| res_src_lo | output | 16 | Current source pointer |
| res_cnt | output | 16 | Current remaining count |
| res_dst_lo | output | 16 | Current destination pointer |
| restart_pc | output | 16 | Program counter to resume from |
| byte_sel | output | 1 | Byte-position flag for restart |

## Verification
A table of short copies covers single words, multi-word runs, a forward overlap in which destination and source share words, a code-base offset and a zero count. These patterns separate a correct sequential copy from a block that reads ahead, ignores the base or still touches memory on a zero count. Directed runs then raise the interrupt after a chosen word, with enable low and with enable high, from both instruction positions. Each interrupted run is reissued from its result outputs, which shows whether the saved state really resumes. Long-mode runs log every write to the bank address, with and without words to copy and with an interrupt. A start pulse made in mid-copy confirms that busy operations cannot be disturbed.

// File: rtl/blkcp_pkg.sv
package blkcp_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_BANK_RD,
        S_BANK_WR,
        S_CHECK,
        S_WRITE,
        S_RESTORE,
        S_FIN,
        S_INTX
    } blkcp_state_e;
endpackage

// File: rtl/blkcp_bankword.sv
module blkcp_bankword #(
    parameter int W        = 16,
    parameter int LOW_BITS = 2
) (
    input  logic [W-1:0] src_hi,
    input  logic [W-1:0] dst_hi,
    output logic [W-1:0] bank_val
);
    localparam logic [W-1:0] LOW_MASK = W'((1 << LOW_BITS) - 1);

    // source high bits shifted up, destination high bits in the low field
    assign bank_val = W'(src_hi << LOW_BITS) | (dst_hi & LOW_MASK);
endmodule

// File: rtl/blkcp_srcaddr.sv
module blkcp_srcaddr #(
    parameter int W = 16
) (
    input  logic [W-1:0] src_ptr,
    input  logic [W-1:0] base,
    input  logic         code_en,
    output logic [W-1:0] rd_addr
);
    assign rd_addr = code_en ? (src_ptr + base) : src_ptr;
endmodule

// File: rtl/blkcp_restart.sv
module blkcp_restart #(
    parameter int W = 16
) (
    input  logic [W-1:0] pc_cur,
    input  logic         even,
    output logic [W-1:0] pc_resume,
    output logic         bsel
);
    // even start: step back one instruction word and clear byte position
    assign pc_resume = even ? (pc_cur - W'(1)) : pc_cur;
    assign bsel      = ~even;
endmodule

// File: rtl/blk_copy_engine.sv
module blk_copy_engine
    import blkcp_pkg::*;
#(
    parameter int             W         = 16,
    parameter int             BANK_LOW  = 2,
    parameter logic [W-1:0]   BANK_ADDR = 16'h00F0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         long_mode,
    input  logic         code_src,
    input  logic         even_pos,
    input  logic [W-1:0] op_src_lo,
    input  logic [W-1:0] op_src_hi,
    input  logic [W-1:0] op_cnt,
    input  logic [W-1:0] op_dst_lo,
    input  logic [W-1:0] op_dst_hi,
    input  logic [W-1:0] code_base,
    input  logic [W-1:0] pc_in,
    input  logic         irq_pending,
    input  logic         irq_enable,
    output logic         mem_req,
    output logic         mem_we,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    output logic         busy,
    output logic         done,
    output logic         interrupted,
    output logic [W-1:0] res_src_lo,
    output logic [W-1:0] res_cnt,
    output logic [W-1:0] res_dst_lo,
    output logic [W-1:0] restart_pc,
    output logic         byte_sel
);
    typedef struct packed {
        blkcp_state_e st;
        logic [W-1:0] src_lo;
        logic [W-1:0] src_hi;
        logic [W-1:0] cnt;
        logic [W-1:0] dst_lo;
        logic [W-1:0] dst_hi;
        logic [W-1:0] base;
        logic [W-1:0] saved;
        logic [W-1:0] pc;
        logic         bsel;
        logic         long_m;
        logic         code_m;
        logic         even_m;
        logic         take_int;
    } regs_t;

    regs_t r_q, r_d;

    logic [W-1:0] bank_val;
    logic [W-1:0] rd_addr;
    logic [W-1:0] pc_resume;
    logic         bsel_resume;
    logic         irq_take;

    blkcp_bankword #(.W(W), .LOW_BITS(BANK_LOW)) u_bank (
        .src_hi   (r_q.src_hi),
        .dst_hi   (r_q.dst_hi),
        .bank_val (bank_val)
    );

    blkcp_srcaddr #(.W(W)) u_src (
        .src_ptr (r_q.src_lo),
        .base    (r_q.base),
        .code_en (r_q.code_m),
        .rd_addr (rd_addr)
    );

    blkcp_restart #(.W(W)) u_rst (
        .pc_cur    (r_q.pc),
        .even      (r_q.even_m),
        .pc_resume (pc_resume),
        .bsel      (bsel_resume)
    );

    assign irq_take = irq_pending & irq_enable;

    always_comb begin
        r_d         = r_q;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        done        = 1'b0;
        interrupted = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.src_lo   = op_src_lo;
                    r_d.src_hi   = op_src_hi;
                    r_d.cnt      = op_cnt;
                    r_d.dst_lo   = op_dst_lo;
                    r_d.dst_hi   = op_dst_hi;
                    r_d.base     = code_base;
                    r_d.pc       = pc_in;
                    r_d.bsel     = 1'b0;
                    r_d.long_m   = long_mode;
                    r_d.code_m   = code_src;
                    r_d.even_m   = even_pos;
                    r_d.take_int = 1'b0;
                    r_d.st       = long_mode ? S_BANK_RD : S_CHECK;
                end
            end
            S_BANK_RD: begin
                mem_req  = 1'b1;
                mem_addr = BANK_ADDR;
                r_d.st   = S_BANK_WR;
            end
            S_BANK_WR: begin
                r_d.saved = mem_rdata;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = BANK_ADDR;
                mem_wdata = bank_val;
                r_d.st    = S_CHECK;
            end
            S_CHECK: begin
                if (r_q.cnt == '0) begin
                    r_d.st = r_q.long_m ? S_RESTORE : S_FIN;
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = rd_addr;
                    r_d.cnt  = r_q.cnt - W'(1);
                    r_d.st   = S_WRITE;
                end
            end
            S_WRITE: begin
                mem_req    = 1'b1;
                mem_we     = 1'b1;
                mem_addr   = r_q.dst_lo;
                mem_wdata  = mem_rdata;
                r_d.src_lo = r_q.src_lo + W'(1);
                r_d.dst_lo = r_q.dst_lo + W'(1);
                if (irq_take) begin
                    r_d.take_int = 1'b1;
                    r_d.pc       = pc_resume;
                    r_d.bsel     = bsel_resume;
                    r_d.st       = r_q.long_m ? S_RESTORE : S_INTX;
                end else begin
                    r_d.st = S_CHECK;
                end
            end
            S_RESTORE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = BANK_ADDR;
                mem_wdata = r_q.saved;
                r_d.st    = r_q.take_int ? S_INTX : S_FIN;
            end
            S_FIN: begin
                done   = 1'b1;
                r_d.st = S_IDLE;
            end
            S_INTX: begin
                interrupted = 1'b1;
                r_d.st      = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != S_IDLE);
    assign res_src_lo = r_q.src_lo;
    assign res_cnt    = r_q.cnt;
    assign res_dst_lo = r_q.dst_lo;
    assign restart_pc = r_q.pc;
    assign byte_sel   = r_q.bsel;

    // ---------------- assertions ----------------
    assert_status_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && interrupted));

    assert_pulse_short_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || interrupted) |=> !busy && !done && !interrupted);

    assert_we_has_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    assert_zero_noaccess_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_CHECK && res_cnt == '0) |-> !mem_req);

    assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_CHECK && res_cnt != '0) |=> res_cnt == $past(res_cnt) - W'(1));

    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_WRITE) |=> (res_dst_lo == $past(res_dst_lo) + W'(1))
                              && (res_src_lo == $past(res_src_lo) + W'(1)));

    assert_irq_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_WRITE && !(irq_pending && irq_enable)) |=> busy && !interrupted);

    assert_irq_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_WRITE && irq_pending && irq_enable) |=> !(mem_req && !mem_we));

    assert_bank_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || interrupted) && r_q.long_m)
            |-> $past(mem_req && mem_we && mem_addr == BANK_ADDR));
endmodule

// File: tb/blk_copy_engine_test.sv
`timescale 1ns/1ps
module blk_copy_engine_test;
    localparam logic [15:0] BANK_A    = 16'h00F0;
    localparam logic [15:0] BANK_INIT = 16'h1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, long_mode = 1'b0, code_src = 1'b0, even_pos = 1'b1;
    logic [15:0] op_src_lo = '0, op_src_hi = '0, op_cnt = '0, op_dst_lo = '0, op_dst_hi = '0;
    logic [15:0] code_base = '0, pc_in = '0;
    logic        irq_pending = 1'b0, irq_enable = 1'b0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, done, interrupted, byte_sel;
    logic [15:0] res_src_lo, res_cnt, res_dst_lo, restart_pc;

    always #2 clk = ~clk;

    blk_copy_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .long_mode(long_mode),
        .code_src(code_src), .even_pos(even_pos),
        .op_src_lo(op_src_lo), .op_src_hi(op_src_hi), .op_cnt(op_cnt),
        .op_dst_lo(op_dst_lo), .op_dst_hi(op_dst_hi), .code_base(code_base),
        .pc_in(pc_in), .irq_pending(irq_pending), .irq_enable(irq_enable),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .interrupted(interrupted),
        .res_src_lo(res_src_lo), .res_cnt(res_cnt), .res_dst_lo(res_dst_lo),
        .restart_pc(restart_pc), .byte_sel(byte_sel)
    );

    // memory model: one-cycle read latency
    logic [15:0] mem [256];
    logic [15:0] shadow [256];
    logic        preload = 1'b0;
    logic [15:0] rdata_q = '0;
    assign mem_rdata = rdata_q;

    always @(posedge clk) begin
        if (preload) begin
            for (int i = 0; i < 256; i++) mem[i] <= 16'hA000 + 16'(i * 3);
            mem[BANK_A[7:0]] <= BANK_INIT;
        end else if (mem_req && mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end else if (mem_req) begin
            rdata_q <= mem[mem_addr[7:0]];
        end
    end

    // monitor
    int          n_checks = 0, n_bad = 0;
    int          data_reads = 0, data_writes = 0, bank_n = 0;
    logic [15:0] bank_log [4];
    logic [15:0] read_addr_log [16];
    logic        irq_arm = 1'b0;
    int          irq_k = 0;

    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (mem_addr == BANK_A) begin
                if (mem_we && bank_n < 4) bank_log[bank_n] = mem_wdata;
                if (mem_we) bank_n++;
            end else if (mem_we) begin
                data_writes++;
                if (irq_arm && data_writes == irq_k) irq_pending = 1'b1;
            end else begin
                if (data_reads < 16) read_addr_log[data_reads] = mem_addr;
                data_reads++;
            end
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary_exit();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    // Runs one operation, models it, and checks the result
    task automatic run_op(input logic lm, input logic cm, input logic ev,
                          input logic [15:0] s, input logic [15:0] sh, input logic [15:0] c,
                          input logic [15:0] d, input logic [15:0] dh, input logic [15:0] b,
                          input logic [15:0] pc, input logic en, input logic arm, input int k,
                          input logic poke, input string rtag);
        int m;
        logic exp_int;
        int guard;
        exp_int = en && arm && (k >= 1) && (k <= int'(c));
        m = exp_int ? k : int'(c);
        @(negedge clk);
        data_reads = 0; data_writes = 0; bank_n = 0;
        irq_pending = 1'b0; irq_arm = arm; irq_k = k; irq_enable = en;
        long_mode = lm; code_src = cm; even_pos = ev;
        op_src_lo = s; op_src_hi = sh; op_cnt = c; op_dst_lo = d; op_dst_hi = dh;
        code_base = b; pc_in = pc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10", "busy after start", {31'd0, busy}, 32'd1);
        guard = 0;
        while (!(done || interrupted) && guard < 2000) begin
            if (poke && guard == 2) begin
                start = 1'b1; op_src_lo = 16'h00AA; op_cnt = 16'd1; op_dst_lo = 16'h00AB;
            end else if (poke && guard == 3) begin
                start = 1'b0; op_src_lo = s; op_cnt = c; op_dst_lo = d;
            end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        check(rtag, "status done", {31'd0, done}, {31'd0, !exp_int});
        check("R5", "status interrupted", {31'd0, interrupted}, {31'd0, exp_int});
        check("R3", "res_cnt", {16'd0, res_cnt}, {16'd0, 16'(int'(c) - m)});
        check("R3", "res_src_lo", {16'd0, res_src_lo}, {16'd0, 16'(int'(s) + m)});
        check("R3", "res_dst_lo", {16'd0, res_dst_lo}, {16'd0, 16'(int'(d) + m)});
        if (exp_int) begin
            check("R9", "restart_pc", {16'd0, restart_pc}, {16'd0, ev ? pc - 16'd1 : pc});
            check("R9", "byte_sel", {31'd0, byte_sel}, {31'd0, !ev});
        end
        @(negedge clk);
        check("R10", "busy clear after status", {31'd0, busy}, 32'd0);
        check("R10", "status pulse one cycle", {30'd0, done, interrupted}, 32'd0);
        // reference model of the copy
        for (int i = 0; i < m; i++) begin
            logic [7:0] sa, da;
            sa = 8'(s + 16'(i) + (cm ? b : 16'd0));
            da = 8'(d + 16'(i));
            shadow[da] = shadow[sa];
        end
        check("R2", "data reads", data_reads, m);
        check(rtag, "data writes", data_writes, m);
        if (cm && m > 0)
            check("R6", "first read addr", {16'd0, read_addr_log[0]}, {16'd0, s + b});
        for (int i = 0; i < 256; i++) begin
            if (i != int'(BANK_A[7:0]) && mem[i] !== shadow[i])
                check(rtag, $sformatf("mem[%0h]", i), {16'd0, mem[i]}, {16'd0, shadow[i]});
        end
        n_checks++;
        if (lm) begin
            check("R11", "bank writes", bank_n, 2);
            check("R7", "bank value", {16'd0, bank_log[0]}, {16'd0, 16'(sh << 2) | (dh & 16'd3)});
            check("R8", "bank restore", {16'd0, bank_log[1]}, {16'd0, BANK_INIT});
            check("R8", "bank final", {16'd0, mem[BANK_A[7:0]]}, {16'd0, BANK_INIT});
        end else begin
            check("R1", "no bank writes", bank_n, 0);
        end
        irq_arm = 1'b0; irq_pending = 1'b0;
    endtask

    // src, cnt, dst, code base (nonzero base => code-source mode)
    localparam logic [63:0] VEC [6] = '{
        {16'h0010, 16'd4, 16'h0040, 16'h0000},
        {16'h0020, 16'd1, 16'h0060, 16'h0000},
        {16'h0030, 16'd8, 16'h0034, 16'h0000},
        {16'h0005, 16'd3, 16'h0070, 16'h0020},
        {16'h0050, 16'd0, 16'h0080, 16'h0000},
        {16'h0090, 16'd6, 16'h008E, 16'h0000}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary_exit();
    end

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = 16'hA000 + 16'(i * 3);
        shadow[BANK_A[7:0]] = BANK_INIT;
        repeat (2) @(negedge clk);
        check("R1", "reset busy", {31'd0, busy}, 32'd0);
        check("R1", "reset status", {30'd0, done, interrupted}, 32'd0);
        check("R1", "reset mem_req", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        preload = 1'b1;
        @(negedge clk);
        preload = 1'b0;

        // table of short copies (R1, R2, R3, R6)
        for (int v = 0; v < 6; v++) begin
            logic [15:0] bs;
            bs = VEC[v][15:0];
            run_op(1'b0, bs != 0, 1'b1, VEC[v][63:48], 16'd0, VEC[v][47:32],
                   VEC[v][31:16], 16'd0, bs, 16'd200, 1'b0, 1'b0, 0, 1'b0,
                   bs != 0 ? "R6" : "R1");
        end

        // R4: pending interrupt with enable low is ignored
        run_op(1'b0, 1'b0, 1'b1, 16'h00A0, 0, 16'd5, 16'h00B0, 0, 0, 16'd300, 1'b0, 1'b1, 2, 1'b0, "R4");

        // R5/R9: interrupt after 2 of 5 from even position, then resume
        run_op(1'b0, 1'b0, 1'b1, 16'h0011, 0, 16'd5, 16'h00C0, 0, 0, 16'd100, 1'b1, 1'b1, 2, 1'b0, "R5");
        run_op(1'b0, 1'b0, 1'b1, res_src_lo, 0, res_cnt, res_dst_lo, 0, 0, 16'd99, 1'b0, 1'b0, 0, 1'b0, "R5");

        // R9: odd position, interrupt on the last word
        run_op(1'b0, 1'b0, 1'b0, 16'h0021, 0, 16'd3, 16'h00C8, 0, 0, 16'd50, 1'b1, 1'b1, 3, 1'b0, "R9");
        run_op(1'b0, 1'b0, 1'b0, res_src_lo, 0, res_cnt, res_dst_lo, 0, 0, 16'd50, 1'b0, 1'b0, 0, 1'b0, "R2");

        // R7/R8: long copy
        run_op(1'b1, 1'b0, 1'b1, 16'h0012, 16'h0005, 16'd3, 16'h00D0, 16'h0006, 0, 16'd10, 1'b0, 1'b0, 0, 1'b0, "R7");
        // R11: long zero count
        run_op(1'b1, 1'b0, 1'b1, 16'h0012, 16'h4003, 16'd0, 16'h00D0, 16'h0007, 0, 16'd10, 1'b0, 1'b0, 0, 1'b0, "R11");
        // R8: long interrupted copy restores bank before exit
        run_op(1'b1, 1'b0, 1'b0, 16'h0040, 16'h0001, 16'd4, 16'h00E0, 16'h0002, 0, 16'd77, 1'b1, 1'b1, 1, 1'b0, "R8");
        // R10: start during a busy copy is ignored
        run_op(1'b1, 1'b0, 1'b1, 16'h0060, 16'h0002, 16'd4, 16'h00E8, 16'h0001, 0, 16'd5, 1'b0, 1'b0, 0, 1'b1, "R10");

        summary_exit();
    end
endmodule